// File: doc/BRIEF.md
# Supervisor Watchdog with Startup Delay

This block watches a host processor for signs of life on behalf of a power-sequencing supervisor. The processor proves it is running by pulsing a kick input. If the processor fails to kick before a programmable number of slow timebase ticks has elapsed, the block raises a reset request for a fixed number of ticks.

There are two ways to arm the block, chosen by one mode bit. In the sequencing-tied mode (`mode_indep_i = 0`) it waits until power sequencing has finished and the system reset has been released. In the free-running mode (`mode_indep_i = 1`) it ignores sequencing and arms once the supply is above lockout and boot has finished. After every reset event it can first apply a long startup delay, chosen by a 3-bit code, so that a slow boot can finish before routine kicking begins. A separate 3-bit code sets the normal timeout.

Every transition is registered. Each output therefore reflects the decision taken at the previous rising clock edge.

Top module: `wdsup_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `wd_rst_o` and `active_o` are both 0.
- R2: With mode bit 0, the block arms only when `seq_done_i`, `rst_released_i` and `supply_ok_i` are all 1 and `reset_evt_i` is 0, whatever the value of `boot_done_i`.
- R3: With mode bit 1, the block arms when `supply_ok_i` and `boot_done_i` are 1 and `reset_evt_i` is 0, whatever the values of `seq_done_i` and `rst_released_i`.
- R4: If the startup code `start_code_i` is nonzero at arming, the first timeout lasts GRACE_UNIT << (code-1) ticks. A code of 000 skips the delay and loads the normal timeout directly.
- R5: The normal timeout lasts WATCH_UNIT*(`tmo_code_i`+1) ticks. `wd_rst_o` rises on the tick that uses up the count when no kick came with it. An arming edge does not consume a tick.
- R6: A kick while armed reloads the normal timeout and takes priority over a tick in the same cycle. A kick during the startup delay ends the delay at once.
- R7: After expiry, `wd_rst_o` stays 1 for BITE_TICKS ticks, with `active_o` 0 and kicks ignored. The block then drops to disarmed, and on re-arming it applies the startup delay again.
- R8: While armed, a `reset_evt_i` pulse, or the arming condition of the latched mode going false (for example a supply drop), disarms the block on the next cycle.
- R9: The mode bit is latched only while the block is disarmed. A change made while armed takes effect only after the next disarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Slow timebase pulse, one clock wide |
| kick_i | input | 1 | Host processor activity pulse |
| seq_done_i | input | 1 | Power sequencing complete |
| rst_released_i | input | 1 | System reset output released |
| supply_ok_i | input | 1 | Supply above undervoltage lockout |
| boot_done_i | input | 1 | Boot phase finished |
| reset_evt_i | input | 1 | Reset event pulse (reboot, manual reset, enable cycle) |
| mode_indep_i | input | 1 | 0 = sequencing-tied arming, 1 = free-running arming |
| start_code_i | input | 3 | Startup delay code, 000 = none |
| tmo_code_i | input | 3 | Normal timeout code |
| wd_rst_o | output | 1 | Watchdog reset request |
| active_o | output | 1 | Watchdog armed (startup delay or normal watch) |

## Verification
Arming, kicks, tick expiry and disarm events are all sampled at a rising edge. Their effect on `active_o` and `wd_rst_o` is visible from that same edge on, so each result is due exactly one clock after its stimulus is presented. The bench's reference model advances on the rising edge from the same input values the design sees. Outputs are compared on the falling edge of every cycle, so every one-cycle latency is checked rather than assumed. The bench changes stimulus only on falling edges, which keeps the stimulus edge distinct from the sampling edge.

// File: rtl/wdsup_pkg.sv
package wdsup_pkg;

  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_GRACE = 2'd1,
    WS_WATCH = 2'd2,
    WS_BITE  = 2'd3
  } wd_state_e;

  // Startup delay in ticks: grows by doubling with the code, 0 = disabled.
  function automatic int unsigned grace_ticks(input logic [2:0] code,
                                              input int unsigned unit);
    if (code == 3'd0) return 0;
    return unit << (int'(code) - 1);
  endfunction

  // Normal timeout in ticks: linear in the code, never zero.
  function automatic int unsigned watch_ticks(input logic [2:0] code,
                                              input int unsigned unit);
    return unit * (int'(code) + 1);
  endfunction

endpackage

// File: rtl/wdsup_gate.sv
module wdsup_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic idle_i,
  input  logic mode_i,
  input  logic seq_done_i,
  input  logic rst_rel_i,
  input  logic supply_ok_i,
  input  logic boot_done_i,
  input  logic reset_evt_i,
  output logic arm_o,
  output logic drop_o
);
  logic       mode_q, mode_d;
  logic [1:0] cond;

  // cond[0]: sequencing-tied, cond[1]: free-running
  always_comb begin
    cond[0] = seq_done_i & rst_rel_i & supply_ok_i;
    cond[1] = supply_ok_i & boot_done_i;
  end

  always_comb begin
    mode_d = mode_q;
    if (idle_i) mode_d = mode_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= mode_d;
  end

  always_comb begin
    arm_o  = cond[mode_i] & ~reset_evt_i;
    drop_o = reset_evt_i | ~cond[mode_q];
  end
endmodule

// File: rtl/wdsup_count.sv
module wdsup_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)                       cnt_d = load_val_i;
    else if (dec_i && cnt_q != '0)    cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == ONE);
endmodule

// File: rtl/wdsup_ctrl.sv
module wdsup_ctrl
  import wdsup_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int GRACE_UNIT = 4,
  parameter int WATCH_UNIT = 2,
  parameter int BITE_TICKS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             kick_i,
  input  logic             arm_i,
  input  logic             drop_i,
  input  logic [2:0]       grace_code_i,
  input  logic [2:0]       watch_code_i,
  input  logic             cnt_last_i,
  output wd_state_e        state_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             dec_o
);
  localparam logic [CNT_W-1:0] BITE_LD = CNT_W'(BITE_TICKS);

  wd_state_e        st_q, st_d;
  logic [CNT_W-1:0] grace_val, watch_val;

  always_comb begin
    grace_val = CNT_W'(grace_ticks(grace_code_i, GRACE_UNIT));
    watch_val = CNT_W'(watch_ticks(watch_code_i, WATCH_UNIT));
  end

  always_comb begin
    st_d       = st_q;
    load_o     = 1'b0;
    load_val_o = '0;
    dec_o      = 1'b0;
    case (st_q)
      WS_IDLE: begin
        if (arm_i) begin
          load_o = 1'b1;
          if (grace_code_i != 3'd0) begin
            st_d       = WS_GRACE;
            load_val_o = grace_val;
          end else begin
            st_d       = WS_WATCH;
            load_val_o = watch_val;
          end
        end
      end
      WS_GRACE, WS_WATCH: begin
        if (drop_i) begin
          st_d = WS_IDLE;
        end else if (kick_i) begin
          st_d       = WS_WATCH;
          load_o     = 1'b1;
          load_val_o = watch_val;
        end else if (tick_i) begin
          if (cnt_last_i) begin
            st_d       = WS_BITE;
            load_o     = 1'b1;
            load_val_o = BITE_LD;
          end else begin
            dec_o = 1'b1;
          end
        end
      end
      WS_BITE: begin
        if (tick_i) begin
          if (cnt_last_i) st_d = WS_IDLE;
          else            dec_o = 1'b1;
        end
      end
      default: st_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= WS_IDLE;
    else        st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/wdsup_top.sv
module wdsup_top
  import wdsup_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int GRACE_UNIT = 4,
  parameter int WATCH_UNIT = 2,
  parameter int BITE_TICKS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       kick_i,
  input  logic       seq_done_i,
  input  logic       rst_released_i,
  input  logic       supply_ok_i,
  input  logic       boot_done_i,
  input  logic       reset_evt_i,
  input  logic       mode_indep_i,
  input  logic [2:0] start_code_i,
  input  logic [2:0] tmo_code_i,
  output logic       wd_rst_o,
  output logic       active_o
);
  wd_state_e        state;
  logic             arm, drop, load, dec, last;
  logic [CNT_W-1:0] load_val;

  wdsup_gate u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .idle_i      (state == WS_IDLE),
    .mode_i      (mode_indep_i),
    .seq_done_i  (seq_done_i),
    .rst_rel_i   (rst_released_i),
    .supply_ok_i (supply_ok_i),
    .boot_done_i (boot_done_i),
    .reset_evt_i (reset_evt_i),
    .arm_o       (arm),
    .drop_o      (drop)
  );

  wdsup_ctrl #(
    .CNT_W      (CNT_W),
    .GRACE_UNIT (GRACE_UNIT),
    .WATCH_UNIT (WATCH_UNIT),
    .BITE_TICKS (BITE_TICKS)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_i),
    .kick_i       (kick_i),
    .arm_i        (arm),
    .drop_i       (drop),
    .grace_code_i (start_code_i),
    .watch_code_i (tmo_code_i),
    .cnt_last_i   (last),
    .state_o      (state),
    .load_o       (load),
    .load_val_o   (load_val),
    .dec_o        (dec)
  );

  wdsup_count #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .load_val_i (load_val),
    .dec_i      (dec),
    .last_o     (last)
  );

  assign wd_rst_o = (state == WS_BITE);
  assign active_o = (state == WS_GRACE) || (state == WS_WATCH);
endmodule

// File: rtl/wdsup_chk.sv
module wdsup_chk (
  input logic clk,
  input logic rst_n,
  input logic tick_i,
  input logic kick_i,
  input logic seq_done_i,
  input logic rst_released_i,
  input logic supply_ok_i,
  input logic boot_done_i,
  input logic reset_evt_i,
  input logic mode_indep_i,
  input logic wd_rst_o,
  input logic active_o
);
  // R2: sequencing-tied arming needs its full condition
  a_r2_dep_gate: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(active_o) && !$past(mode_indep_i) && !$past(wd_rst_o) && !$past(active_o))
      |-> $past(seq_done_i && rst_released_i && supply_ok_i && !reset_evt_i));

  // R3: free-running arming needs supply and boot
  a_r3_indep_gate: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(active_o) && $past(mode_indep_i))
      |-> $past(supply_ok_i && boot_done_i && !reset_evt_i));

  // R5 / R6: expiry only on a tick without a kick
  a_r5_expiry_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_rst_o) |-> $past(tick_i && !kick_i && active_o));

  // R7: the request holds between ticks
  a_r7_bite_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_rst_o && !tick_i) |=> wd_rst_o);

  // R7: the request ends in the disarmed state
  a_r7_bite_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_rst_o) |-> !active_o);

  // R8: a reset event disarms an armed watchdog
  a_r8_event_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && reset_evt_i) |=> !active_o);

  // R8: a supply loss disarms an armed watchdog
  a_r8_supply_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && !supply_ok_i) |=> !active_o);

  // R7: request and armed status never overlap
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(wd_rst_o && active_o));
endmodule

bind wdsup_top wdsup_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .tick_i         (tick_i),
  .kick_i         (kick_i),
  .seq_done_i     (seq_done_i),
  .rst_released_i (rst_released_i),
  .supply_ok_i    (supply_ok_i),
  .boot_done_i    (boot_done_i),
  .reset_evt_i    (reset_evt_i),
  .mode_indep_i   (mode_indep_i),
  .wd_rst_o       (wd_rst_o),
  .active_o       (active_o)
);

// File: tb/wdsup_top_test.sv
`timescale 1ns/1ps
module wdsup_top_test;
  localparam int CLK_P  = 10;
  localparam int GUNIT  = 4;
  localparam int WUNIT  = 2;
  localparam int BTICKS = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_i, kick_i, seq_done_i, rst_released_i, supply_ok_i;
  logic       boot_done_i, reset_evt_i, mode_indep_i;
  logic [2:0] start_code_i, tmo_code_i;
  logic       wd_rst_o, active_o;

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  bit    tick_run = 0;
  int    ph = 0;
  bit    done = 0;

  // reference model state: 0 disarmed, 1 startup, 2 watching, 3 reset request
  int m_st;
  int m_left;
  bit m_mode;

  always #(CLK_P/2) clk = ~clk;

  wdsup_top #(.CNT_W(16), .GRACE_UNIT(GUNIT), .WATCH_UNIT(WUNIT),
              .BITE_TICKS(BTICKS)) uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .kick_i(kick_i),
    .seq_done_i(seq_done_i), .rst_released_i(rst_released_i),
    .supply_ok_i(supply_ok_i), .boot_done_i(boot_done_i),
    .reset_evt_i(reset_evt_i), .mode_indep_i(mode_indep_i),
    .start_code_i(start_code_i), .tmo_code_i(tmo_code_i),
    .wd_rst_o(wd_rst_o), .active_o(active_o)
  );

  function automatic bit cond_for(bit m);
    if (m) return supply_ok_i && boot_done_i;
    return seq_done_i && rst_released_i && supply_ok_i;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_left = 0; m_mode = 0;
    end else begin
      case (m_st)
        0: begin
          if (cond_for(mode_indep_i) && !reset_evt_i) begin
            if (start_code_i != 0) begin
              m_st = 1; m_left = GUNIT << (int'(start_code_i) - 1);
            end else begin
              m_st = 2; m_left = WUNIT * (int'(tmo_code_i) + 1);
            end
          end
          m_mode = mode_indep_i;
        end
        1, 2: begin
          if (reset_evt_i || !cond_for(m_mode)) m_st = 0;
          else if (kick_i) begin m_st = 2; m_left = WUNIT * (int'(tmo_code_i) + 1); end
          else if (tick_i) begin
            if (m_left == 1) begin m_st = 3; m_left = BTICKS; end
            else m_left = m_left - 1;
          end
        end
        default: begin
          if (tick_i) begin
            if (m_left == 1) m_st = 0;
            else m_left = m_left - 1;
          end
        end
      endcase
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_cmp++;
      if (wd_rst_o !== (m_st == 3) || active_o !== (m_st == 1 || m_st == 2)) begin
        n_bad++;
        $display("FAIL %s: rst/act actual %b%b expected %b%b", cur_req,
                 wd_rst_o, active_o, (m_st == 3), (m_st == 1 || m_st == 2));
      end
    end
  end

  // timebase: one tick every third cycle
  always @(negedge clk) begin
    if (!tick_run) begin
      tick_i <= 1'b0;
    end else begin
      ph     <= (ph == 2) ? 0 : ph + 1;
      tick_i <= (ph == 2);
    end
  end

  task automatic check_eq(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic kick();
    @(negedge clk) kick_i = 1'b1;
    @(negedge clk) kick_i = 1'b0;
  endtask

  task automatic evt();
    @(negedge clk) reset_evt_i = 1'b1;
    @(negedge clk) reset_evt_i = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; kick_i = 0; seq_done_i = 0; rst_released_i = 0;
    supply_ok_i = 0; boot_done_i = 0; reset_evt_i = 0; mode_indep_i = 0;
    start_code_i = 3'd0; tmo_code_i = 3'd1;
    repeat (3) @(negedge clk);
    // R1: outputs low under reset
    check_eq("R1", wd_rst_o, 1'b0);
    check_eq("R1", active_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1", active_o, 1'b0);
    tick_run = 1;

    // R2: sequencing-tied mode waits for sequencing
    cur_req = "R2";
    supply_ok_i = 1; boot_done_i = 1; rst_released_i = 1; seq_done_i = 0;
    wait_cyc(30);
    check_eq("R2", active_o, 1'b0);
    seq_done_i = 1;
    wait_cyc(1);
    check_eq("R2", active_o, 1'b1);

    // R5: no kicks, repeated expiry; R7 request pulse and re-arm
    cur_req = "R5";
    wait_cyc(40);
    cur_req = "R7";
    wait_cyc(40);

    // R4: startup delay code 2, then code 0 path
    cur_req = "R4";
    start_code_i = 3'd2;
    evt();
    wait_cyc(2);
    check_eq("R4", active_o, 1'b1);
    wait_cyc(80);

    // R6: kicks keep it alive; kick during startup ends the delay
    cur_req = "R6";
    evt();
    wait_cyc(5);
    for (int i = 0; i < 12; i++) begin
      kick();
      wait_cyc(5);
      check_eq("R6", wd_rst_o, 1'b0);
    end
    tmo_code_i = 3'd3;
    for (int i = 0; i < 6; i++) begin kick(); wait_cyc(15); end
    check_eq("R6", active_o, 1'b1);

    // R8: supply drop and reset event both disarm
    cur_req = "R8";
    supply_ok_i = 0;
    wait_cyc(2);
    check_eq("R8", active_o, 1'b0);
    supply_ok_i = 1;
    wait_cyc(10);
    evt();
    wait_cyc(30);

    // R3: free-running mode ignores sequencing
    cur_req = "R3";
    mode_indep_i = 1; seq_done_i = 0; rst_released_i = 0; start_code_i = 3'd0;
    wait_cyc(4);
    check_eq("R3", active_o, 1'b1);
    for (int i = 0; i < 5; i++) begin kick(); wait_cyc(6); end

    // R9: mode change while armed has no effect until disarmed
    cur_req = "R9";
    mode_indep_i = 0;
    wait_cyc(3);
    check_eq("R9", active_o, 1'b1);
    kick();
    evt();
    wait_cyc(10);
    check_eq("R9", active_o, 1'b0);
    seq_done_i = 1; rst_released_i = 1;
    wait_cyc(2);
    check_eq("R9", active_o, 1'b1);

    // R4: longest startup delay code 7
    cur_req = "R4";
    start_code_i = 3'd7; tmo_code_i = 3'd0;
    evt();
    wait_cyc(800);
    cur_req = "R7";
    wait_cyc(20);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule